// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block steers an external analog-to-digital conversion engine through a contiguous range of input channels. Software programs a configuration register with a scan mode, a first channel and a last channel. A start trigger then launches a scan. For each channel the sequencer presents the channel number, issues a one-cycle conversion request, and waits for the engine's done pulse. When the pulse arrives, the returned 10-bit sample is captured together with the channel it belongs to.

There are four scan behaviours. Two are single-shot variants, which differ only in whether a trigger can restart a running scan. The third is a free-running loop. The fourth is a step mode that converts one channel per trigger. Software reads a busy flag in the same register, and writing a zero to that flag stops any scan in progress.

The engine is expected to abandon its current conversion when it receives a new request. The result of an abandoned conversion is never reported.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, busy, convReq and resValid are 0 and regRdData reads all zeros.
- R2: regRdData returns the stored configuration with the layout bit 0 = busy, bits 2:1 = mode, bits 6:3 = first channel, bits 10:7 = last channel; a write updates mode and both channel fields.
- R3: In modes 00 and 01 an accepted trigger converts every channel from the first through the last in ascending order. Busy is then cleared and no further request is issued.
- R4: In mode 00, a trigger that arrives while a channel is being converted abandons that channel, reports no result for it, and restarts the scan at the first channel.
- R5: In mode 01, triggers that arrive during a scan do not change the sequence of converted channels.
- R6: In mode 10, after the last channel the scan continues at the first channel with no further trigger. Triggers during the scan are ignored.
- R7: In mode 11, each accepted trigger converts exactly one channel and the sequencer then idles with busy held at 1. After the last channel, the next trigger converts the first channel again. Triggers that arrive during a conversion are ignored.
- R8: When the last channel is numerically below the first, the channel number counts up through 15, wraps to 0, and continues to the last channel.
- R9: A register write with bit 0 = 0 terminates any running or paused scan. Busy reads 0 from the next cycle, and no further request or result follows.
- R10: A register write with bit 0 = 1 never sets busy and never starts a scan.
- R11: Each accepted done pulse produces a resValid pulse of exactly one cycle on the next cycle, with resData holding the sample and resCh holding the channel it was taken from.
- R12: convReq is high only while busy is 1. It lasts one cycle unless a restart arrives in that cycle, and chSel holds the requested channel until the done pulse is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Configuration register write strobe |
| regWrData | input | 11 | Write data: busy, mode, first and last channel |
| regRdData | output | 11 | Register readback with the same layout |
| startTrig | input | 1 | Scan start trigger, one cycle per event |
| chSel | output | 4 | Channel presented to the conversion engine |
| convReq | output | 1 | Conversion request strobe |
| convDone | input | 1 | Engine completion pulse |
| convResult | input | 10 | Engine sample, valid with convDone |
| resData | output | 10 | Last captured sample |
| resCh | output | 4 | Channel of the last captured sample |
| resValid | output | 1 | One-cycle pulse marking a fresh capture |
| busy | output | 1 | Scan active or paused |

## Verification
The bound checker enforces the cycle-level rules on every cycle. These are: an abort clears busy on the next cycle, a write of one never sets busy, requests appear only while busy and last one cycle, result pulses never repeat back to back, and in mode 01 a trigger during a scan leaves the channel unchanged. Some properties only show up over a whole scan, so the bench's scenarios must cover them. These are the complete channel order for every first/last pair (including the wrap through zero), the discarded channel and fresh start on a mode 00 restart, the unprompted wrap of mode 10, and the one-channel-per-trigger stepping and wrap of mode 11.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    MODE_ONCE_RESTART = 2'b00,
    MODE_ONCE_LOCKED  = 2'b01,
    MODE_LOOP         = 2'b10,
    MODE_STEP         = 2'b11
  } scanMode_e;

  // strobes from the sequencer control to the datapath
  typedef struct packed {
    logic loadStart;
    logic advance;
    logic latchRes;
    logic setBusy;
    logic clrBusy;
  } seqStrobe_t;

endpackage

// File: rtl/adc_scan_dp.sv
module adc_scan_dp
  import adc_scan_pkg::*;
#(
  parameter int CH_W  = 4,
  parameter int RES_W = 10,
  localparam int REG_W = 3 + 2 * CH_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  seqStrobe_t       stb,
  input  logic             convDone,
  input  logic [RES_W-1:0] convResult,
  output scanMode_e        mode,
  output logic             atEnd,
  output logic             abortReq,
  output logic [CH_W-1:0]  chSel,
  output logic             busy,
  output logic [RES_W-1:0] resData,
  output logic [CH_W-1:0]  resCh,
  output logic             resValid
);

  localparam int FIRST_LO = 3;
  localparam int LAST_LO  = 3 + CH_W;

  scanMode_e       cfgMode;
  logic [CH_W-1:0] cfgFirst;
  logic [CH_W-1:0] cfgLast;
  logic [CH_W-1:0] curCh;

  assign abortReq = regWrEn & ~regWrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgMode  <= MODE_ONCE_RESTART;
      cfgFirst <= '0;
      cfgLast  <= '0;
    end else if (regWrEn) begin
      cfgMode  <= scanMode_e'(regWrData[2:1]);
      cfgFirst <= regWrData[FIRST_LO +: CH_W];
      cfgLast  <= regWrData[LAST_LO +: CH_W];
    end
  end

  // channel pointer: natural modulo-2^CH_W increment gives the wrap through 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              curCh <= '0;
    else if (stb.loadStart) curCh <= cfgFirst;
    else if (stb.advance)   curCh <= atEnd ? cfgFirst : curCh + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            busy <= 1'b0;
    else if (stb.clrBusy) busy <= 1'b0;
    else if (stb.setBusy) busy <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resData  <= '0;
      resCh    <= '0;
      resValid <= 1'b0;
    end else begin
      resValid <= stb.latchRes;
      if (stb.latchRes) begin
        resData <= convResult;
        resCh   <= curCh;
      end
    end
  end

  assign mode      = cfgMode;
  assign atEnd     = (curCh == cfgLast);
  assign chSel     = curCh;
  assign regRdData = {cfgLast, cfgFirst, cfgMode, busy};

  logic unusedDone;
  assign unusedDone = convDone;

endmodule

// File: rtl/adc_scan_ctl.sv
module adc_scan_ctl
  import adc_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startTrig,
  input  logic       convDone,
  input  scanMode_e  mode,
  input  logic       atEnd,
  input  logic       abortReq,
  output seqStrobe_t stb,
  output logic       convReq
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_PAUSE} seqState_e;

  seqState_e state, nxtState;
  logic      restart;

  assign restart = startTrig && (mode == MODE_ONCE_RESTART);

  always_comb begin
    stb      = '0;
    nxtState = state;
    if (abortReq) begin
      stb.clrBusy = 1'b1;
      nxtState    = S_IDLE;
    end else begin
      unique case (state)
        S_IDLE: if (startTrig) begin
          stb.loadStart = 1'b1;
          stb.setBusy   = 1'b1;
          nxtState      = S_REQ;
        end
        S_REQ: begin
          if (restart) stb.loadStart = 1'b1;
          else         nxtState      = S_WAIT;
        end
        S_WAIT: begin
          if (restart) begin
            stb.loadStart = 1'b1;
            nxtState      = S_REQ;
          end else if (convDone) begin
            stb.latchRes = 1'b1;
            if (atEnd && !mode[1]) begin
              stb.clrBusy = 1'b1;
              nxtState    = S_IDLE;
            end else begin
              stb.advance = 1'b1;
              nxtState    = (mode == MODE_STEP) ? S_PAUSE : S_REQ;
            end
          end
        end
        S_PAUSE: if (startTrig) nxtState = S_REQ;
        default: nxtState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxtState;
  end

  assign convReq = (state == S_REQ);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int CH_W  = 4,
  parameter int RES_W = 10,
  localparam int REG_W = 3 + 2 * CH_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             startTrig,
  output logic [CH_W-1:0]  chSel,
  output logic             convReq,
  input  logic             convDone,
  input  logic [RES_W-1:0] convResult,
  output logic [RES_W-1:0] resData,
  output logic [CH_W-1:0]  resCh,
  output logic             resValid,
  output logic             busy
);

  seqStrobe_t stb;
  scanMode_e  mode;
  logic       atEnd;
  logic       abortReq;

  adc_scan_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .startTrig (startTrig),
    .convDone  (convDone),
    .mode      (mode),
    .atEnd     (atEnd),
    .abortReq  (abortReq),
    .stb       (stb),
    .convReq   (convReq)
  );

  adc_scan_dp #(.CH_W(CH_W), .RES_W(RES_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .stb        (stb),
    .convDone   (convDone),
    .convResult (convResult),
    .mode       (mode),
    .atEnd      (atEnd),
    .abortReq   (abortReq),
    .chSel      (chSel),
    .busy       (busy),
    .resData    (resData),
    .resCh      (resCh),
    .resValid   (resValid)
  );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int CH_W  = 4,
  parameter int REG_W = 3 + 2 * CH_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [REG_W-1:0] regWrData,
  input logic [REG_W-1:0] regRdData,
  input logic             startTrig,
  input logic [CH_W-1:0]  chSel,
  input logic             convReq,
  input logic             convDone,
  input logic             resValid,
  input logic             busy
);

  p_abort_clears_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regWrData[0]) |=> !busy);

  p_write_one_inert_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && regWrEn && regWrData[0] && !startTrig) |=> !busy);

  p_req_while_busy_r12: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> busy);

  p_req_single_cycle_r12: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && !startTrig) |=> !convReq);

  p_valid_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  p_locked_ignores_trig_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regRdData[2:1] == 2'b01 && startTrig && !convDone && !regWrEn)
      |=> $stable(chSel));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .startTrig (startTrig),
  .chSel     (chSel),
  .convReq   (convReq),
  .convDone  (convDone),
  .resValid  (resValid),
  .busy      (busy)
);

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;

  localparam int PERIOD = 10;
  localparam int CH_W   = 4;
  localparam int RES_W  = 10;
  localparam int REG_W  = 3 + 2 * CH_W;
  localparam int LAT    = 3;
  localparam int WDOG   = 150000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWrEn = 1'b0;
  logic [REG_W-1:0] regWrData = '0;
  logic [REG_W-1:0] regRdData;
  logic             startTrig = 1'b0;
  logic [CH_W-1:0]  chSel;
  logic             convReq;
  logic             convDone;
  logic [RES_W-1:0] convResult;
  logic [RES_W-1:0] resData;
  logic [CH_W-1:0]  resCh;
  logic             resValid;
  logic             busy;

  int vecCnt = 0;
  int missCnt = 0;
  int cycles = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  adc_scan_seq u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .startTrig(startTrig), .chSel(chSel),
    .convReq(convReq), .convDone(convDone), .convResult(convResult),
    .resData(resData), .resCh(resCh), .resValid(resValid), .busy(busy)
  );

  function automatic logic [RES_W-1:0] sampleOf(input int ch);
    return RES_W'((ch * 37 + 5) % 1024);
  endfunction

  // conversion engine model: a new request replaces any conversion in flight
  logic            engBusy = 1'b0;
  int              engCnt = 0;
  logic [CH_W-1:0] engCh = '0;
  assign convDone   = engBusy && (engCnt == 0);
  assign convResult = sampleOf(int'(engCh));

  always @(posedge clk) begin
    if (convReq) begin
      engBusy <= 1'b1;
      engCnt  <= LAT - 1;
      engCh   <= chSel;
    end else if (engBusy) begin
      if (engCnt == 0) engBusy <= 1'b0;
      else             engCnt  <= engCnt - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecCnt++;
    if (!ok) begin
      missCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // result log, sampled a quarter period after each rising edge
  int logCh [64];
  int logDat[64];
  int logN = 0;
  logic prevValid = 1'b0;

  always begin
    @(posedge clk);
    #(PERIOD/4);
    if (rstN) begin
      if (resValid && logN < 64) begin
        logCh[logN]  = int'(resCh);
        logDat[logN] = int'(resData);
        logN++;
      end
      if (resValid && prevValid) chk(0, "R11 back-to-back valid", 1, 0);
      if (convDone && busy) chk(chSel == engCh, "R12 chSel held", int'(chSel), int'(engCh));
      if (convReq) chk(busy == 1'b1, "R12 request needs busy", int'(busy), 1);
    end
    prevValid = resValid;
  end

  // all drive tasks start and end at a falling edge
  task automatic wrReg(input logic [1:0] m, input int first, input int last, input bit b);
    regWrData = {CH_W'(last), CH_W'(first), m, b};
    regWrEn   = 1'b1;
    @(negedge clk);
    regWrEn   = 1'b0;
  endtask

  task automatic trig();
    startTrig = 1'b1;
    @(negedge clk);
    startTrig = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic waitLog(input int n);
    for (int i = 0; i < 2000 && logN < n; i++) @(negedge clk);
  endtask

  int expCh[64];

  task automatic chkLog(input string req, input int n);
    chk(logN == n, req, logN, n);
    for (int i = 0; i < n && i < logN; i++) begin
      chk(logCh[i] == expCh[i], req, logCh[i], expCh[i]);
      chk(logDat[i] == int'(sampleOf(expCh[i])), req, logDat[i], int'(sampleOf(expCh[i])));
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG && !finished) begin
      finished = 1;
      missCnt++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(convReq == 1'b0, "R1 convReq", int'(convReq), 0);
    chk(resValid == 1'b0, "R1 resValid", int'(resValid), 0);
    chk(regRdData == '0, "R1 readback", int'(regRdData), 0);

    // R2 register layout
    wrReg(2'b10, 7, 12, 1'b0);
    chk(regRdData == {4'd12, 4'd7, 2'b10, 1'b0}, "R2 readback", int'(regRdData),
        int'({4'd12, 4'd7, 2'b10, 1'b0}));

    // R10 writing one to busy does nothing
    logN = 0;
    wrReg(2'b01, 0, 3, 1'b1);
    idle(10);
    chk(busy == 1'b0, "R10 busy stays clear", int'(busy), 0);
    chk(logN == 0, "R10 no scan started", logN, 0);

    // R3 R8 R11 sweep of every first/last pair in locked single-shot mode
    for (int s = 0; s < 16; s++) begin
      for (int e = 0; e < 16; e++) begin
        int n;
        n = ((e - s) & 15) + 1;
        for (int i = 0; i < n; i++) expCh[i] = (s + i) & 15;
        wrReg(2'b01, s, e, 1'b0);
        logN = 0;
        trig();
        chk(busy == 1'b1, "R3 busy on trigger", int'(busy), 1);
        waitIdle();
        idle(LAT + 3);
        chkLog((e < s) ? "R8 wrapped scan" : "R3 single scan", n);
        chk(busy == 1'b0 && convReq == 1'b0, "R3 stopped", int'(busy), 0);
      end
    end

    // R5 triggers ignored while a locked scan runs
    wrReg(2'b01, 2, 5, 1'b0);
    logN = 0;
    trig();
    trig();
    idle(3);
    trig();
    waitLog(2);
    trig();
    waitIdle();
    idle(LAT + 3);
    for (int i = 0; i < 4; i++) expCh[i] = 2 + i;
    chkLog("R5 locked ignores trigger", 4);

    // R4 restart in mode 00 while the third channel is in flight
    wrReg(2'b00, 1, 4, 1'b0);
    logN = 0;
    trig();
    waitLog(2);
    @(negedge clk);
    trig();
    waitIdle();
    idle(LAT + 3);
    expCh[0] = 1; expCh[1] = 2;
    for (int i = 0; i < 4; i++) expCh[2 + i] = 1 + i;
    chkLog("R4 restart discards channel", 6);

    // R6 continuous mode with wrap, then R9 abort
    wrReg(2'b10, 14, 1, 1'b0);
    logN = 0;
    trig();
    waitLog(4);
    trig();
    waitLog(10);
    wrReg(2'b10, 14, 1, 1'b0);
    chk(busy == 1'b0, "R9 abort clears busy", int'(busy), 1'b0);
    idle(LAT + 6);
    for (int i = 0; i < 10; i++) expCh[i] = (14 + (i % 4)) & 15;
    chkLog("R6 continuous loop", 10);
    chk(busy == 1'b0 && convReq == 1'b0, "R9 no activity after abort", int'(convReq), 0);

    // R7 step mode: one channel per trigger, wrap, busy held
    wrReg(2'b11, 3, 5, 1'b0);
    logN = 0;
    trig();
    trig();
    idle(12);
    chk(logN == 1, "R7 one channel per trigger", logN, 1);
    chk(busy == 1'b1, "R7 busy while paused", int'(busy), 1);
    trig(); idle(12);
    trig(); idle(12);
    trig(); idle(12);
    expCh[0] = 3; expCh[1] = 4; expCh[2] = 5; expCh[3] = 3;
    chkLog("R7 step and wrap", 4);
    chk(busy == 1'b1, "R7 busy after wrap", int'(busy), 1);
    wrReg(2'b11, 3, 5, 1'b0);
    idle(LAT + 3);
    chk(busy == 1'b0, "R9 abort paused scan", int'(busy), 0);
    chk(logN == 4, "R9 no result after abort", logN, 4);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

endmodule